// File: doc/BRIEF.md
# Serial Control Word Register File

This block receives control words on a three-wire, write-only serial link and keeps the three settings those words address. The three settings are left volume, right volume and a general control word. The sender drives a serial clock and a data line, and it changes the data while the serial clock is low. The block takes one bit on each rising edge of the serial clock. When the sender has shifted a full 16-bit word, it raises a separate latch line. That rising edge commits the word. The link has no chip-select framing.

The word is sent most significant bit first. Its two lowest bits choose the destination register, and its upper 14 bits are the value written. The three serial pins are asynchronous to the core clock. They pass through synchronizers, and their edges are detected in the core clock domain. Each register therefore updates in one core cycle, together with a one-cycle pulse that names the register written.

Top module: `ctl_port_regfile`

## Requirements
- R1: When synchronous active-low reset is applied, both volume outputs hold all ones (0x3FFF), the control output holds zero, and no update pulse is raised.
- R2: Bits are taken on rising edges of the serial clock, most significant bit first. In the committed word, bits [15:2] are the register value and bits [1:0] are the select code.
- R3: Select code 00 writes bits [15:2] to the left volume output.
- R4: Select code 01 writes bits [15:2] to the right volume output.
- R5: Select code 10 writes bits [15:2] to the control output.
- R6: Select code 11 changes no output and raises no update pulse.
- R7: When more than 16 bits arrive before the latch, only the last 16 bits form the word.
- R8: A latch rise that follows fewer than 16 serial bits since the previous latch rise or reset is ignored, and the bit count restarts.
- R9: A register output changes only in the cycle its update pulse is high. Shifting bits alone never changes an output.
- R10: Each accepted write raises exactly one update pulse, for the addressed register only, lasting one core clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, valid at serial clock rise |
| ser_latch | input | 1 | Commit strobe, rising edge commits the word |
| vol_left | output | 14 | Left volume register |
| vol_right | output | 14 | Right volume register |
| ctrl_word | output | 14 | Control register |
| upd_left | output | 1 | One-cycle pulse when left volume is written |
| upd_right | output | 1 | One-cycle pulse when right volume is written |
| upd_ctrl | output | 1 | One-cycle pulse when the control register is written |

## Verification
The main path is driven with one word for each select code. Each word carries a distinct value, so a swapped or mis-decoded destination shows up on the wrong output. The reserved code 11 carries a non-zero value, which separates "ignored" from "written with zero".

A 20-bit burst with leading ones checks that the word is the last 16 bits received and not the first 16. A 10-bit burst followed by a latch checks the minimum bit count. A normal write right after it checks that the count restarts. The outputs and pulse counts are also checked after shifting but before the latch, which separates commit-on-latch from commit-on-shift.

// File: rtl/ctl_port_pkg.sv
// Shared definitions for the serial control register file.
// Assumes three destination registers chosen by a two-bit select code.
package ctl_port_pkg;

    localparam int SEL_W    = 2;
    localparam int NUM_REGS = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_LEFT  = 2'b00,
        SEL_RIGHT = 2'b01,
        SEL_CTRL  = 2'b10,
        SEL_NONE  = 2'b11
    } sel_e;

endpackage

// File: rtl/ctl_pin_sync.sv
// Brings WIDTH asynchronous pins into the core clock domain through
// STAGES flops each, and flags a rising edge of each synchronized pin.
// Assumes each pin stays at one level for several core cycles.
module ctl_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] prev_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the pin through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], pins_i[b]};
        end

        assign level_o[b] = chain_q[STAGES-1];
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_o;
    end

    assign rise_o = level_o & ~prev_q;

endmodule

// File: rtl/ctl_shifter.sv
// Collects serial bits MSB first and counts them up to WORD_W.
// On a latch strobe after at least WORD_W bits, it presents the last
// WORD_W bits with a one-cycle commit. Shorter bursts are dropped.
// Assumes bit and latch strobes are single-cycle core-domain pulses.
module ctl_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb_i,
    input  logic              bit_val_i,
    input  logic              latch_stb_i,
    output logic [WORD_W-1:0] word_o,
    output logic              commit_o
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    logic [WORD_W-1:0] shift_q;
    logic [CNT_W-1:0]  cnt_q;

    // Shift in one bit for each serial clock rise; older bits drop out.
    always_ff @(posedge clk) begin
        if (!rst_n)         shift_q <= '0;
        else if (bit_stb_i) shift_q <= {shift_q[WORD_W-2:0], bit_val_i};
    end

    // Count bits since the last latch, saturating at a full word.
    always_ff @(posedge clk) begin
        if (!rst_n)                               cnt_q <= '0;
        else if (latch_stb_i)                     cnt_q <= '0;
        else if (bit_stb_i && cnt_q != CNT_FULL)  cnt_q <= cnt_q + 1'b1;
    end

    // Capture the word and raise commit when a full word is latched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o   <= '0;
            commit_o <= 1'b0;
        end else begin
            commit_o <= latch_stb_i && (cnt_q == CNT_FULL);
            if (latch_stb_i && (cnt_q == CNT_FULL)) word_o <= shift_q;
        end
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);

    p_commit_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(cnt_q) == CNT_FULL);

    p_latch_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb_i |=> cnt_q == '0);

endmodule

// File: rtl/ctl_regbank.sv
// Holds the three destination registers. On a commit it decodes the
// select code in the low bits of the word and loads the upper bits into
// the chosen register, with a one-cycle update pulse for that register.
// Assumes commit is a single-cycle pulse.
module ctl_regbank
    import ctl_port_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic [WORD_W-1:0]       word_i,
    output logic [WORD_W-SEL_W-1:0] reg_o [NUM_REGS],
    output logic [NUM_REGS-1:0]     upd_o
);

    localparam int DATA_W = WORD_W - SEL_W;

    sel_e              sel;
    logic [DATA_W-1:0] data;

    assign sel  = sel_e'(word_i[SEL_W-1:0]);
    assign data = word_i[WORD_W-1:SEL_W];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Volumes reset to full scale, the control word to zero.
        localparam logic [DATA_W-1:0] RST_VAL = (g < 2) ? '1 : '0;
        logic hit;

        assign hit = commit_i && (sel == sel_e'(g));

        // Load the register and pulse its update flag on a matching commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_o[g] <= RST_VAL;
                upd_o[g] <= 1'b0;
            end else begin
                upd_o[g] <= hit;
                if (hit) reg_o[g] <= data;
            end
        end

        p_change_needs_upd_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_o[g] != $past(reg_o[g])) |-> upd_o[g]);

        p_upd_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
            upd_o[g] |=> !upd_o[g]);
    end

    p_upd_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_o));

    p_reserved_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && sel == SEL_NONE) |=> upd_o == '0);

endmodule

// File: rtl/ctl_port_regfile.sv
// Top of the serial control register file. Synchronizes the serial
// clock, data and latch pins to the core clock, shifts the word and
// writes the addressed register. Assumes the serial clock and latch
// levels each last at least three core cycles.
module ctl_port_regfile
    import ctl_port_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_clk,
    input  logic                    ser_data,
    input  logic                    ser_latch,
    output logic [WORD_W-SEL_W-1:0] vol_left,
    output logic [WORD_W-SEL_W-1:0] vol_right,
    output logic [WORD_W-SEL_W-1:0] ctrl_word,
    output logic                    upd_left,
    output logic                    upd_right,
    output logic                    upd_ctrl
);

    localparam int DATA_W = WORD_W - SEL_W;
    localparam int PIN_W  = 3;

    logic [PIN_W-1:0]    pin_lvl;
    logic [PIN_W-1:0]    pin_rise;
    logic [WORD_W-1:0]   word;
    logic                commit;
    logic [DATA_W-1:0]   regs [NUM_REGS];
    logic [NUM_REGS-1:0] upd;

    ctl_pin_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  ({ser_latch, ser_data, ser_clk}),
        .level_o (pin_lvl),
        .rise_o  (pin_rise)
    );

    ctl_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb_i   (pin_rise[0]),
        .bit_val_i   (pin_lvl[1]),
        .latch_stb_i (pin_rise[2]),
        .word_o      (word),
        .commit_o    (commit)
    );

    ctl_regbank #(
        .WORD_W (WORD_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .word_i   (word),
        .reg_o    (regs),
        .upd_o    (upd)
    );

    assign vol_left  = regs[0];
    assign vol_right = regs[1];
    assign ctrl_word = regs[2];
    assign upd_left  = upd[0];
    assign upd_right = upd[1];
    assign upd_ctrl  = upd[2];

endmodule

// File: tb/test_ctl_port_regfile.sv
module test_ctl_port_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_latch = 1'b0;
    logic [13:0] vol_left, vol_right, ctrl_word;
    logic        upd_left, upd_right, upd_ctrl;

    int n_checks = 0;
    int n_fails  = 0;
    int cnt_l = 0, cnt_r = 0, cnt_c = 0;
    int base_l, base_r, base_c;
    logic [13:0] exp_l = 14'h3FFF, exp_r = 14'h3FFF, exp_c = 14'h0000;

    always #4 clk = ~clk;   // 125 MHz

    ctl_port_regfile i_ctl_port_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_latch (ser_latch),
        .vol_left  (vol_left),
        .vol_right (vol_right),
        .ctrl_word (ctrl_word),
        .upd_left  (upd_left),
        .upd_right (upd_right),
        .upd_ctrl  (upd_ctrl)
    );

    // Count update pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (upd_left)  cnt_l++;
            if (upd_right) cnt_r++;
            if (upd_ctrl)  cnt_c++;
        end
    end

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic snap();
        base_l = cnt_l; base_r = cnt_r; base_c = cnt_c;
    endtask

    task automatic check_all(input string req, input int pl, input int pr, input int pc);
        check(req, "vol_left",  int'(vol_left),  int'(exp_l));
        check(req, "vol_right", int'(vol_right), int'(exp_r));
        check(req, "ctrl_word", int'(ctrl_word), int'(exp_c));
        check(req, "left pulses",  cnt_l - base_l, pl);
        check(req, "right pulses", cnt_r - base_r, pr);
        check(req, "ctrl pulses",  cnt_c - base_c, pc);
    endtask

    // Send the low n bits of v, MSB first; data changes while ser_clk is low.
    task automatic send_bits(input int n, input logic [31:0] v);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            wait_cyc(8);
            ser_clk = 1'b1;
            wait_cyc(8);
            ser_clk = 1'b0;
        end
        wait_cyc(8);
    endtask

    task automatic pulse_latch();
        ser_latch = 1'b1;
        wait_cyc(8);
        ser_latch = 1'b0;
        wait_cyc(8);
    endtask

    task automatic test_reset();
        snap();
        check_all("R1", 0, 0, 0);
    endtask

    // R2 R3 R9: write left, check the outputs are still idle before the latch.
    task automatic test_left();
        snap();
        send_bits(16, {16'h0, 14'h1234, 2'b00});
        check_all("R9", 0, 0, 0);
        pulse_latch();
        exp_l = 14'h1234;
        check_all("R3", 1, 0, 0);
    endtask

    task automatic test_right();
        snap();
        send_bits(16, {16'h0, 14'h0ABC, 2'b01});
        pulse_latch();
        exp_r = 14'h0ABC;
        check_all("R4", 0, 1, 0);
    endtask

    task automatic test_ctrl();
        snap();
        send_bits(16, {16'h0, 14'h2AA5, 2'b10});
        pulse_latch();
        exp_c = 14'h2AA5;
        check_all("R5", 0, 0, 1);
    endtask

    task automatic test_reserved();
        snap();
        send_bits(16, {16'h0, 14'h0555, 2'b11});
        pulse_latch();
        check_all("R6", 0, 0, 0);
    endtask

    task automatic test_long_burst();
        snap();
        send_bits(20, {12'h0, 4'hF, 14'h0001, 2'b00});
        pulse_latch();
        exp_l = 14'h0001;
        check_all("R7", 1, 0, 0);
    endtask

    task automatic test_short_burst();
        snap();
        send_bits(10, 32'h0000_02A9);
        pulse_latch();
        check_all("R8", 0, 0, 0);
        snap();
        send_bits(16, {16'h0, 14'h3C0F, 2'b01});
        pulse_latch();
        exp_r = 14'h3C0F;
        check_all("R8", 0, 1, 0);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        test_reset();
        test_left();
        test_right();
        test_ctrl();
        test_reserved();
        test_long_burst();
        test_short_burst();
        snap();
        send_bits(16, {16'h0, 14'h0777, 2'b10});
        pulse_latch();
        exp_c = 14'h0777;
        check_all("R10", 0, 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule